// File: doc/BRIEF.md
# Sixteen-Bit Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry-in and returns a 16-bit sum, a carry-out and a signed overflow flag. It has no clock and no storage. Every output follows its inputs in the same cycle. A system clock can therefore sample the results on the edge after the operands settle.

The operands are split into four 4-bit slices. Each slice forms per-bit generate (a AND b) and propagate (a XOR b) terms. From these it computes its internal carries as flat sums of products of the generate terms, the propagate terms and the slice carry-in. No internal carry feeds another carry. Each slice also reports a slice generate and a slice propagate.

A second-level lookahead unit takes the four slice pairs and the carry-in. It uses the same sum-of-products equations to produce the carries into bits 4, 8 and 12 and the final carry-out. No carry travels from one slice to the next. Slice width and slice count are parameters. The defaults give 16 bits.

Top module: `cla16_adder`

## Requirements
- R1: `sum_out` equals the low 16 bits of `opnd_a + opnd_b + carry_in`, with operands taken as unsigned.
- R2: `carry_out` equals bit 16 of that unsigned 17-bit total.
- R3: `ovf_flag` is 1 exactly when the carry into bit 15 differs from the carry out of bit 15. Put another way, it is 1 when both operands have the same bit-15 sign and the sum's bit 15 differs from it.
- R4: When every bit propagates (`opnd_b == ~opnd_a`), the carry-in passes through the whole adder. With `carry_in` = 0 the sum is 0xFFFF and the carry-out is 0. With `carry_in` = 1 the sum is 0x0000 and the carry-out is 1.
- R5: The longest carry path gives the exact result. 0xFFFF + 0x0000 + 1 yields sum 0x0000, carry-out 1 and no overflow. 0xFFFF + 0x0001 + 0 yields the same outputs.
- R6: A carry that leaves one slice reaches the next slice at each boundary (bit 3→4, 7→8, 11→12). For example, 0x000F + 0x0001 = 0x0010 and 0x0FFF + 0x0001 = 0x1000.
- R7: The design is purely combinational. After an input change, the outputs are correct within the same clock period, with no clock or reset input.
- R8: All-zero inputs give sum 0x0000, carry-out 0 and overflow 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 16 | First addend |
| opnd_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Low 16 bits of the total |
| carry_out | output | 1 | Carry out of bit 15 |
| ovf_flag | output | 1 | Signed (two's complement) overflow |

## Verification
The block holds no state, so any faulty lookahead term appears on the ports in the same period that the inputs excite it. The failure shows as a wrong sum bit at a slice boundary, a wrong carry-out, or a wrong overflow flag. A fault in a slice's generate or propagate output shows only when a carry must cross that boundary. For that reason the stimulus includes directed full-propagate and boundary-crossing vectors in addition to random operands. A fault in the top-level carry only shows up when it disagrees with the carry-out of the most significant slice. That comparison runs on every input change.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int DEF_SLICE_W  = 4;
  localparam int DEF_SLICE_N  = 4;
  localparam int DEF_TOTAL_W  = DEF_SLICE_W * DEF_SLICE_N;
endpackage

// File: rtl/cla_lookahead.sv
// Flat sum-of-products lookahead: each carry is built from gen/prop and c0 only.
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         c0_i,
  output logic [N-1:0] carry_o,     // carry_o[k] = carry out of position k
  output logic         blk_gen_o,
  output logic         blk_prop_o
);

  // carry out of position top, expanded as OR of product terms
  function automatic logic sop_carry(input logic [N-1:0] g, input logic [N-1:0] p,
                                     input logic c, input int top);
    logic acc;
    logic prod;
    acc = 1'b0;
    for (int j = 0; j <= top; j++) begin
      prod = g[j];
      for (int m = j + 1; m <= top; m++) prod = prod & p[m];
      acc = acc | prod;
    end
    prod = c;
    for (int m = 0; m <= top; m++) prod = prod & p[m];
    return acc | prod;
  endfunction

  for (genvar k = 0; k < N; k++) begin : g_carry
    assign carry_o[k] = sop_carry(gen_i, prop_i, c0_i, k);
  end

  assign blk_gen_o  = sop_carry(gen_i, prop_i, 1'b0, N - 1);
  assign blk_prop_o = &prop_i;

  // The flat products must agree with the one-step recurrence (R6).
  always_comb begin
    if (!$isunknown({gen_i, prop_i, c0_i})) begin
      p_first_carry_r6: assert (carry_o[0] == (gen_i[0] | (prop_i[0] & c0_i)))
        else $error("p_first_carry_r6");
      for (int k = 1; k < N; k++) begin
        p_carry_chain_r6: assert (carry_o[k] == (gen_i[k] | (prop_i[k] & carry_o[k-1])))
          else $error("p_carry_chain_r6");
      end
      // Block pair summarises the carry out for any carry-in (R4).
      p_blk_pair_r4: assert (carry_o[N-1] == (blk_gen_o | (blk_prop_o & c0_i)))
        else $error("p_blk_pair_r4");
    end
  end

endmodule

// File: rtl/cla_group.sv
// One slice: per-bit generate/propagate, internal lookahead, sum bits.
module cla_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         grp_gen_o,
  output logic         grp_prop_o,
  output logic         grp_cout_o
);

  logic [W-1:0] bit_gen;
  logic [W-1:0] bit_prop;
  logic [W-1:0] bit_carry;

  assign bit_gen  = a_i & b_i;
  assign bit_prop = a_i ^ b_i;

  cla_lookahead #(.N(W)) u_la (
    .gen_i      (bit_gen),
    .prop_i     (bit_prop),
    .c0_i       (cin_i),
    .carry_o    (bit_carry),
    .blk_gen_o  (grp_gen_o),
    .blk_prop_o (grp_prop_o)
  );

  assign sum_o[0] = bit_prop[0] ^ cin_i;
  for (genvar k = 1; k < W; k++) begin : g_sum
    assign sum_o[k] = bit_prop[k] ^ bit_carry[k-1];
  end
  assign grp_cout_o = bit_carry[W-1];

  // A slice that fully propagates can never also generate (R4).
  always_comb begin
    if (!$isunknown({a_i, b_i, cin_i})) begin
      p_gen_prop_excl_r4: assert (!(grp_gen_o && grp_prop_o))
        else $error("p_gen_prop_excl_r4");
      p_slice_sum_r1: assert ({grp_cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
        else $error("p_slice_sum_r1");
    end
  end

endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
  import cla_pkg::*;
#(
  parameter int SLICE_W = DEF_SLICE_W,
  parameter int SLICE_N = DEF_SLICE_N
) (
  input  logic [SLICE_W*SLICE_N-1:0] opnd_a,
  input  logic [SLICE_W*SLICE_N-1:0] opnd_b,
  input  logic                       carry_in,
  output logic [SLICE_W*SLICE_N-1:0] sum_out,
  output logic                       carry_out,
  output logic                       ovf_flag
);

  localparam int TW  = SLICE_W * SLICE_N;
  localparam int MSB = TW - 1;

  logic [SLICE_N-1:0] grp_gen;
  logic [SLICE_N-1:0] grp_prop;
  logic [SLICE_N-1:0] grp_cout;
  logic [SLICE_N-1:0] lvl2_carry;
  logic [SLICE_N-1:0] slice_cin;
  logic               all_gen;
  logic               all_prop;
  logic               msb_cin;

  assign slice_cin[0] = carry_in;
  for (genvar i = 1; i < SLICE_N; i++) begin : g_cin
    assign slice_cin[i] = lvl2_carry[i-1];
  end

  for (genvar i = 0; i < SLICE_N; i++) begin : g_slice
    cla_group #(.W(SLICE_W)) u_grp (
      .a_i        (opnd_a[i*SLICE_W +: SLICE_W]),
      .b_i        (opnd_b[i*SLICE_W +: SLICE_W]),
      .cin_i      (slice_cin[i]),
      .sum_o      (sum_out[i*SLICE_W +: SLICE_W]),
      .grp_gen_o  (grp_gen[i]),
      .grp_prop_o (grp_prop[i]),
      .grp_cout_o (grp_cout[i])
    );
  end

  // Second level: same lookahead equations over slice pairs.
  cla_lookahead #(.N(SLICE_N)) u_lvl2 (
    .gen_i      (grp_gen),
    .prop_i     (grp_prop),
    .c0_i       (carry_in),
    .carry_o    (lvl2_carry),
    .blk_gen_o  (all_gen),
    .blk_prop_o (all_prop)
  );

  assign carry_out = lvl2_carry[SLICE_N-1];
  assign msb_cin   = sum_out[MSB] ^ opnd_a[MSB] ^ opnd_b[MSB];
  assign ovf_flag  = carry_out ^ msb_cin;

  always_comb begin
    if (!$isunknown({opnd_a, opnd_b, carry_in})) begin
      p_sum_r1: assert (sum_out == TW'(opnd_a + opnd_b + {{(TW-1){1'b0}}, carry_in}))
        else $error("p_sum_r1");
      p_cout_r2: assert ({carry_out, sum_out} ==
                         ({1'b0, opnd_a} + {1'b0, opnd_b} + {{TW{1'b0}}, carry_in}))
        else $error("p_cout_r2");
      p_no_overflow_r3: assert (ovf_flag == ((opnd_a[MSB] == opnd_b[MSB]) &&
                                             (sum_out[MSB] != opnd_a[MSB])))
        else $error("p_no_overflow_r3");
      p_pass_through_r4: assert (!all_prop || (sum_out == {TW{~carry_in}}))
        else $error("p_pass_through_r4");
      p_gen_forces_cout_r5: assert (!all_gen || carry_out)
        else $error("p_gen_forces_cout_r5");
      for (int i = 0; i < SLICE_N; i++) begin
        p_grp_agree_r6: assert (grp_cout[i] == lvl2_carry[i])
          else $error("p_grp_agree_r6");
      end
    end
  end

endmodule

// File: tb/cla16_adder_test.sv
module cla16_adder_test;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] opnd_a = '0;
  logic [TW-1:0] opnd_b = '0;
  logic          carry_in = 1'b0;
  logic [TW-1:0] sum_out;
  logic          carry_out;
  logic          ovf_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  cla16_adder uut (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .ovf_flag  (ovf_flag)
  );

  function automatic logic [TW:0] ref_total(input logic [TW-1:0] a, input logic [TW-1:0] b,
                                            input logic c);
    return {1'b0, a} + {1'b0, b} + {{TW{1'b0}}, c};
  endfunction

  function automatic logic ref_ovf(input logic [TW-1:0] a, input logic [TW-1:0] b,
                                   input logic c);
    logic [TW:0] t;
    t = ref_total(a, b, c);
    return (a[TW-1] == b[TW-1]) && (t[TW-1] != a[TW-1]);
  endfunction

  task automatic check_vec(input string tag, input logic [TW-1:0] a,
                           input logic [TW-1:0] b, input logic c);
    logic [TW:0] exp_t;
    logic        exp_o;
    @(posedge clk);
    #0.5;
    opnd_a = a; opnd_b = b; carry_in = c;
    @(negedge clk);
    exp_t = ref_total(a, b, c);
    exp_o = ref_ovf(a, b, c);
    n_checks++;
    if ({carry_out, sum_out, ovf_flag} !== {exp_t, exp_o}) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h c=%0d: got sum=%h cout=%0d ovf=%0d exp sum=%h cout=%0d ovf=%0d",
               tag, a, b, c, sum_out, carry_out, ovf_flag, exp_t[TW-1:0], exp_t[TW], exp_o);
    end
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0C1A);
    repeat (2) @(posedge clk);
    // R8 / reset state: zero inputs
    @(negedge clk);
    n_checks++;
    if ({sum_out, carry_out, ovf_flag} !== '0) begin
      n_fail++;
      $display("FAIL R8 reset-state: got %h/%0d/%0d exp 0000/0/0", sum_out, carry_out, ovf_flag);
    end
    rst = 1'b0;
    check_vec("R8 zero", 16'h0000, 16'h0000, 1'b0);
    check_vec("R1 zero+cin", 16'h0000, 16'h0000, 1'b1);
    // R5 longest carry path
    check_vec("R5 ones+cin", 16'hFFFF, 16'h0000, 1'b1);
    check_vec("R5 ones+one", 16'hFFFF, 16'h0001, 1'b0);
    check_vec("R2 ones+ones", 16'hFFFF, 16'hFFFF, 1'b1);
    // R4 full propagate, both carry-in values
    check_vec("R4 alt c0", 16'hAAAA, 16'h5555, 1'b0);
    check_vec("R4 alt c1", 16'hAAAA, 16'h5555, 1'b1);
    check_vec("R4 mix c1", 16'h3C96, 16'hC369, 1'b1);
    // R6 slice boundaries
    check_vec("R6 b4", 16'h000F, 16'h0001, 1'b0);
    check_vec("R6 b8", 16'h00FF, 16'h0001, 1'b0);
    check_vec("R6 b12", 16'h0FFF, 16'h0001, 1'b0);
    check_vec("R6 b12 cin", 16'h0FFF, 16'h0000, 1'b1);
    // R3 overflow both directions and non-overflow near limits
    check_vec("R3 pos ovf", 16'h7FFF, 16'h0001, 1'b0);
    check_vec("R3 neg ovf", 16'h8000, 16'hFFFF, 1'b0);
    check_vec("R3 no ovf", 16'h7FFE, 16'h0000, 1'b1);
    check_vec("R3 neg ok", 16'hFFFD, 16'hFFFB, 1'b0);
    check_vec("R3 min+min", 16'h8000, 16'h8000, 1'b0);
    // R1/R2/R3/R7 random vectors, one new vector per cycle
    for (int i = 0; i < 400; i++) begin
      check_vec("R1 R2 R3 R7 random", 16'($urandom), 16'($urandom), 1'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule